// File: doc/BRIEF.md
# Configuration Retry Handler for a Root Port

This block sits between the host's queue of configuration requests and the link. It takes one configuration read or write from the host and forwards it to the link. It then waits for the completion and decides what the host sees.

A device still finishing its reset may answer with a Configuration Request Retry Status completion. What happens next depends on three things: a visibility enable, the request type, and whether the read touches the Vendor ID field.

- **Visibility on, read covers both Vendor ID bytes.** The handler completes the read to the host at once with a reserved marker value. Software can then poll without stalling the core.
- **Any other retry-status case.** The handler sends the identical request to the link again.
- **Retry limit.** An optional limit turns an endless series of retries into a failed host completion. A limit of zero keeps the unlimited behaviour. That setting is legal but hazardous, because a stuck device can then hang the requester forever.
- **Error completions.** Unsupported Request and Completer Abort completions come back to the host as all-ones data with an error flag set.

Only one request is in flight at a time. The host ready signal stays low from the moment a request is accepted until its final response has been produced.

Top module: `cfg_retry_rp`

## Requirements
- R1: During and right after reset, `host_req_ready` is 1, `link_req_valid` is 0 and `rsp_valid` is 0.
- R2: A request is accepted only while `host_req_ready` is 1. After that, `host_req_ready` stays 0 until the response pulse. Every link issue carries the accepted write flag, register number, byte enables and write data unchanged.
- R3: Take a retry-status completion (`cpl_status` = 3'b010) while `cfg_vis_en` is 1, for a read of register number 0 with byte enables [1:0] both set. The handler responds with no re-issue and `rsp_err` = 0. `rsp_data[15:0]` is 16'h0001. Bytes 2 and 3 are 8'hFF if their byte enable is set and 8'h00 otherwise.
- R4: With `cfg_vis_en` at 0, a retry-status completion makes the handler issue the same request on the link again.
- R5: With `cfg_vis_en` at 1, a retry-status completion for a write, for a register number other than 0, or for a read missing either byte enable [1:0] is re-issued. It is not completed to the host.
- R6: With `cfg_retry_limit` = N > 0, the handler re-issues at most N times. A further retry-status completion ends the request with `rsp_err` = 1 and all-ones data, after N+1 link issues in total.
- R7: With `cfg_retry_limit` = 0, the handler re-issues for as long as retry-status completions keep arriving, and never fails on the count.
- R8: A completion with status Unsupported Request (3'b001), Completer Abort (3'b100) or any other code that is not success or retry gives `rsp_err` = 1 and all-ones `rsp_data`.
- R9: A successful completion (3'b000) gives `rsp_err` = 0. For a read, `rsp_data` equals `cpl_data`. For a write, `rsp_data` is zero.
- R10: The retry count starts from zero for each newly accepted request.
- R11: `rsp_valid` is a single-cycle pulse. `link_req_valid` and the link request fields hold steady until `link_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_vis_en | input | 1 | Retry-status visibility enable |
| cfg_retry_limit | input | LIM_W | Maximum re-issues per request; 0 means unlimited |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Handler idle and able to accept a request |
| host_req_write | input | 1 | 1 = configuration write, 0 = read |
| host_req_reg | input | OFF_W | Dword register number within the function's space |
| host_req_be | input | DATA_W/8 | Byte enables |
| host_req_wdata | input | DATA_W | Write data |
| link_req_valid | output | 1 | Request towards the link |
| link_req_ready | input | 1 | Link takes the request |
| link_req_write | output | 1 | Forwarded write flag |
| link_req_reg | output | OFF_W | Forwarded register number |
| link_req_be | output | DATA_W/8 | Forwarded byte enables |
| link_req_wdata | output | DATA_W | Forwarded write data |
| cpl_valid | input | 1 | Completion from the link |
| cpl_status | input | 3 | 000 success, 001 unsupported, 010 retry, 100 abort |
| cpl_data | input | DATA_W | Completion read data |
| rsp_valid | output | 1 | Final host response pulse |
| rsp_data | output | DATA_W | Host response data |
| rsp_err | output | 1 | Host response marks a failed transaction |

## Verification
The hardest case to reach from the ports is where the retry count meets the limit exactly. One more or one fewer retry-status completion flips the result between success and failure. A related case is a second request that must not inherit the first one's count. The bench plays the link itself and decides, issue by issue, how many retry-status completions to return before a final status. Directed runs therefore hit the counts one below, at and above the limit, back to back under the same limit. A long unlimited run is included as well. Random runs mix visibility, byte enables and register numbers around the Vendor ID decode.

// File: rtl/cfg_retry_rp_pkg.sv
package cfg_retry_rp_pkg;
  localparam logic [2:0] CPL_SC  = 3'b000;
  localparam logic [2:0] CPL_UR  = 3'b001;
  localparam logic [2:0] CPL_CRS = 3'b010;
  localparam logic [2:0] CPL_CA  = 3'b100;

  localparam int VID_BYTES = 2;
  localparam logic [15:0] VID_MARKER = 16'h0001;

  typedef enum logic [1:0] {
    FSM_IDLE  = 2'd0,
    FSM_ISSUE = 2'd1,
    FSM_WAIT  = 2'd2
  } fsm_e;

  typedef enum logic [1:0] {
    ACT_PASS  = 2'd0,
    ACT_SYNTH = 2'd1,
    ACT_FAIL  = 2'd2,
    ACT_RETRY = 2'd3
  } act_e;
endpackage

// File: rtl/cfg_retry_req_hold.sv
module cfg_retry_req_hold #(
  parameter int OFF_W  = 10,
  parameter int DATA_W = 32,
  parameter int LIM_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  bump,
  input  logic                  in_write,
  input  logic [OFF_W-1:0]      in_reg,
  input  logic [DATA_W/8-1:0]   in_be,
  input  logic [DATA_W-1:0]     in_wdata,
  output logic                  q_write,
  output logic [OFF_W-1:0]      q_reg,
  output logic [DATA_W/8-1:0]   q_be,
  output logic [DATA_W-1:0]     q_wdata,
  output logic [LIM_W-1:0]      q_cnt
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [LIM_W-1:0] CNT_MAX = {LIM_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      q_write <= 1'b0;
      q_reg   <= '0;
      q_be    <= '0;
      q_wdata <= '0;
    end else if (load) begin
      q_write <= in_write;
      q_reg   <= in_reg;
      q_be    <= in_be[BE_W-1:0];
      q_wdata <= in_wdata;
    end
  end

  // per-request retry counter, saturating
  always_ff @(posedge clk) begin
    if (rst || load) begin
      q_cnt <= '0;
    end else if (bump && q_cnt != CNT_MAX) begin
      q_cnt <= q_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_retry_classify.sv
module cfg_retry_classify
  import cfg_retry_rp_pkg::*;
#(
  parameter int OFF_W  = 10,
  parameter int DATA_W = 32,
  parameter int LIM_W  = 8
) (
  input  logic                vis_en,
  input  logic                is_write,
  input  logic [OFF_W-1:0]    reg_num,
  input  logic [DATA_W/8-1:0] be,
  input  logic [2:0]          status,
  input  logic [LIM_W-1:0]    limit,
  input  logic [LIM_W-1:0]    cnt,
  output act_e                act
);
  logic vid_cover;
  logic limit_hit;

  assign vid_cover = !is_write && (reg_num == '0) && (&be[VID_BYTES-1:0]);
  assign limit_hit = (limit != '0) && (cnt >= limit);

  always_comb begin
    act = ACT_FAIL;
    if (status == CPL_SC) begin
      act = ACT_PASS;
    end else if (status == CPL_CRS) begin
      if (vis_en && vid_cover) begin
        act = ACT_SYNTH;
      end else if (limit_hit) begin
        act = ACT_FAIL;
      end else begin
        act = ACT_RETRY;
      end
    end
  end
endmodule

// File: rtl/cfg_retry_rsp_build.sv
module cfg_retry_rsp_build
  import cfg_retry_rp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  act_e                act,
  input  logic                is_write,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   cpl_data,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                rsp_err
);
  localparam int BE_W = DATA_W / 8;

  logic [DATA_W-1:0] synth_word;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    if (b < VID_BYTES) begin : g_vid
      assign synth_word[8*b +: 8] = VID_MARKER[8*b +: 8];
    end else begin : g_rest
      assign synth_word[8*b +: 8] = be[b] ? 8'hFF : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        case (act)
          ACT_PASS: begin
            rsp_data <= is_write ? '0 : cpl_data;
            rsp_err  <= 1'b0;
          end
          ACT_SYNTH: begin
            rsp_data <= synth_word;
            rsp_err  <= 1'b0;
          end
          default: begin
            rsp_data <= '1;
            rsp_err  <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_retry_rp.sv
module cfg_retry_rp
  import cfg_retry_rp_pkg::*;
#(
  parameter int OFF_W  = 10,
  parameter int DATA_W = 32,
  parameter int LIM_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_vis_en,
  input  logic [LIM_W-1:0]    cfg_retry_limit,
  input  logic                host_req_valid,
  output logic                host_req_ready,
  input  logic                host_req_write,
  input  logic [OFF_W-1:0]    host_req_reg,
  input  logic [DATA_W/8-1:0] host_req_be,
  input  logic [DATA_W-1:0]   host_req_wdata,
  output logic                link_req_valid,
  input  logic                link_req_ready,
  output logic                link_req_write,
  output logic [OFF_W-1:0]    link_req_reg,
  output logic [DATA_W/8-1:0] link_req_be,
  output logic [DATA_W-1:0]   link_req_wdata,
  input  logic                cpl_valid,
  input  logic [2:0]          cpl_status,
  input  logic [DATA_W-1:0]   cpl_data,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                rsp_err
);
  fsm_e state_q;
  logic accept;
  logic take_cpl;
  logic fire;
  logic bump;
  logic [LIM_W-1:0] cnt;
  act_e act;

  assign host_req_ready = (state_q == FSM_IDLE);
  assign link_req_valid = (state_q == FSM_ISSUE);
  assign accept   = host_req_valid && host_req_ready;
  assign take_cpl = cpl_valid && (state_q == FSM_WAIT);
  assign bump     = take_cpl && (act == ACT_RETRY);
  assign fire     = take_cpl && (act != ACT_RETRY);

  cfg_retry_req_hold #(.OFF_W(OFF_W), .DATA_W(DATA_W), .LIM_W(LIM_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .bump     (bump),
    .in_write (host_req_write),
    .in_reg   (host_req_reg),
    .in_be    (host_req_be),
    .in_wdata (host_req_wdata),
    .q_write  (link_req_write),
    .q_reg    (link_req_reg),
    .q_be     (link_req_be),
    .q_wdata  (link_req_wdata),
    .q_cnt    (cnt)
  );

  cfg_retry_classify #(.OFF_W(OFF_W), .DATA_W(DATA_W), .LIM_W(LIM_W)) u_cls (
    .vis_en   (cfg_vis_en),
    .is_write (link_req_write),
    .reg_num  (link_req_reg),
    .be       (link_req_be),
    .status   (cpl_status),
    .limit    (cfg_retry_limit),
    .cnt      (cnt),
    .act      (act)
  );

  cfg_retry_rsp_build #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .act       (act),
    .is_write  (link_req_write),
    .be        (link_req_be),
    .cpl_data  (cpl_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FSM_IDLE;
    end else begin
      case (state_q)
        FSM_IDLE:  if (accept) state_q <= FSM_ISSUE;
        FSM_ISSUE: if (link_req_ready) state_q <= FSM_WAIT;
        FSM_WAIT: begin
          if (bump) state_q <= FSM_ISSUE;
          else if (fire) state_q <= FSM_IDLE;
        end
        default: state_q <= FSM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_retry_rp_chk.sv
module cfg_retry_rp_chk #(
  parameter int OFF_W  = 10,
  parameter int DATA_W = 32,
  parameter int LIM_W  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_vis_en,
  input logic                host_req_valid,
  input logic                host_req_ready,
  input logic                link_req_valid,
  input logic                link_req_ready,
  input logic                link_req_write,
  input logic [OFF_W-1:0]    link_req_reg,
  input logic [DATA_W/8-1:0] link_req_be,
  input logic                cpl_valid,
  input logic [2:0]          cpl_status,
  input logic                rsp_valid,
  input logic [DATA_W-1:0]   rsp_data,
  input logic                rsp_err
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> host_req_ready && !link_req_valid && !rsp_valid); // R1
  AST_BLOCK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) host_req_valid && host_req_ready |=> !host_req_ready); // R2
  AST_RSP_NEEDS_CPL: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> $past(cpl_valid)); // R2
  AST_MARKER_VALUE: assert property (@(posedge clk) disable iff (rst) rsp_valid && !rsp_err && $past(cpl_valid && cpl_status == 3'b010) |-> rsp_data[15:0] == 16'h0001); // R3
  AST_HIDDEN_RETRY: assert property (@(posedge clk) disable iff (rst) cpl_valid && !host_req_ready && !link_req_valid && cpl_status == 3'b010 && !cfg_vis_en |=> link_req_valid || (rsp_valid && rsp_err)); // R4
  AST_ERR_ONES: assert property (@(posedge clk) disable iff (rst) rsp_valid && rsp_err |-> rsp_data == {DATA_W{1'b1}}); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid); // R11
  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst) link_req_valid && !link_req_ready |=> link_req_valid && $stable(link_req_reg) && $stable(link_req_be) && $stable(link_req_write)); // R11
endmodule

bind cfg_retry_rp cfg_retry_rp_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W), .LIM_W(LIM_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_vis_en     (cfg_vis_en),
  .host_req_valid (host_req_valid),
  .host_req_ready (host_req_ready),
  .link_req_valid (link_req_valid),
  .link_req_ready (link_req_ready),
  .link_req_write (link_req_write),
  .link_req_reg   (link_req_reg),
  .link_req_be    (link_req_be),
  .cpl_valid      (cpl_valid),
  .cpl_status     (cpl_status),
  .rsp_valid      (rsp_valid),
  .rsp_data       (rsp_data),
  .rsp_err        (rsp_err)
);

// File: tb/cfg_retry_rp_test.sv
module cfg_retry_rp_test;
  localparam int OFF_W  = 10;
  localparam int DATA_W = 32;
  localparam int LIM_W  = 8;
  localparam logic [2:0] S_SC = 3'b000, S_UR = 3'b001, S_CRS = 3'b010, S_CA = 3'b100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_vis_en = 1'b0;
  logic [LIM_W-1:0] cfg_retry_limit = '0;
  logic host_req_valid = 1'b0;
  logic host_req_ready;
  logic host_req_write = 1'b0;
  logic [OFF_W-1:0] host_req_reg = '0;
  logic [3:0] host_req_be = '0;
  logic [DATA_W-1:0] host_req_wdata = '0;
  logic link_req_valid;
  logic link_req_ready = 1'b0;
  logic link_req_write;
  logic [OFF_W-1:0] link_req_reg;
  logic [3:0] link_req_be;
  logic [DATA_W-1:0] link_req_wdata;
  logic cpl_valid = 1'b0;
  logic [2:0] cpl_status = '0;
  logic [DATA_W-1:0] cpl_data = '0;
  logic rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic rsp_err;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cfg_retry_rp #(.OFF_W(OFF_W), .DATA_W(DATA_W), .LIM_W(LIM_W)) uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [OFF_W-1:0] rn, input logic [3:0] be,
                         input logic [31:0] wd, input int crs_n, input logic [2:0] fin,
                         input logic [31:0] cdata, input string req);
    int exp_issues;
    logic [31:0] exp_data;
    bit exp_err;
    int lim;
    int issues;
    bit done;
    int guard;
    logic [31:0] got;
    bit gerr;
    lim = int'(cfg_retry_limit);
    if (cfg_vis_en && !wr && rn == '0 && be[1:0] == 2'b11 && crs_n > 0) begin
      exp_issues = 1;
      exp_data = {be[3] ? 8'hFF : 8'h00, be[2] ? 8'hFF : 8'h00, 16'h0001};
      exp_err = 1'b0;
    end else if (lim != 0 && crs_n > lim) begin
      exp_issues = lim + 1;
      exp_data = '1;
      exp_err = 1'b1;
    end else begin
      exp_issues = crs_n + 1;
      if (fin == S_SC) begin
        exp_data = wr ? 32'h0 : cdata;
        exp_err = 1'b0;
      end else begin
        exp_data = '1;
        exp_err = 1'b1;
      end
    end
    guard = 0;
    while (!host_req_ready && guard < 100) begin @(negedge clk); guard++; end
    host_req_valid = 1'b1; host_req_write = wr; host_req_reg = rn;
    host_req_be = be; host_req_wdata = wd;
    @(negedge clk);
    host_req_valid = 1'b0;
    check(!host_req_ready, {req, " R2 ready low while busy"}, {31'b0, host_req_ready}, 32'h0);
    issues = 0; done = 0; got = '0; gerr = 1'b0;
    while (!done && issues < 1000) begin
      guard = 0;
      while (!link_req_valid && guard < 20) begin @(negedge clk); guard++; end
      repeat ($urandom_range(0, 2)) @(negedge clk);
      check(link_req_valid && link_req_write == wr && link_req_reg == rn && link_req_be == be &&
            (wr ? link_req_wdata == wd : 1'b1), {req, " R2 issue fields"},
            {link_req_be, 10'b0, link_req_reg, 7'b0, link_req_valid}, {be, 10'b0, rn, 7'b0, 1'b1});
      link_req_ready = 1'b1;
      @(negedge clk);
      link_req_ready = 1'b0;
      issues++;
      repeat ($urandom_range(0, 2)) @(negedge clk);
      cpl_valid = 1'b1;
      if (issues <= crs_n) begin cpl_status = S_CRS; cpl_data = $urandom; end
      else begin cpl_status = fin; cpl_data = cdata; end
      @(negedge clk);
      cpl_valid = 1'b0;
      if (rsp_valid) begin done = 1; got = rsp_data; gerr = rsp_err; end
    end
    check(issues == exp_issues, {req, " link issue count"}, issues, exp_issues);
    check(got == exp_data, {req, " response data"}, got, exp_data);
    check(gerr == exp_err, {req, " response error flag"}, {31'b0, gerr}, {31'b0, exp_err});
    @(negedge clk);
    check(!rsp_valid && host_req_ready, {req, " R11 single pulse, back to idle"},
          {30'b0, rsp_valid, host_req_ready}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    check(host_req_ready && !link_req_valid && !rsp_valid, "R1 reset state",
          {29'b0, host_req_ready, link_req_valid, rsp_valid}, 32'h4);
    rst = 1'b0;
    @(negedge clk);
    check(host_req_ready && !link_req_valid && !rsp_valid, "R1 after reset",
          {29'b0, host_req_ready, link_req_valid, rsp_valid}, 32'h4);

    // R9 success paths
    cfg_vis_en = 1'b0; cfg_retry_limit = 8'd0;
    run_txn(1'b0, 10'd4, 4'hF, 32'h0, 0, S_SC, 32'hCAFE_0123, "R9 read ok");
    run_txn(1'b1, 10'd1, 4'h3, 32'h1234_5678, 0, S_SC, 32'hFFFF_0000, "R9 write ok");
    // R8 error completions
    run_txn(1'b0, 10'd2, 4'hF, 32'h0, 0, S_UR, 32'h1111_2222, "R8 unsupported");
    run_txn(1'b0, 10'd0, 4'hF, 32'h0, 0, S_CA, 32'h3333_4444, "R8 abort");
    run_txn(1'b0, 10'd0, 4'hF, 32'h0, 0, 3'b111, 32'h5555_6666, "R8 odd code");
    // R4 hidden retries
    run_txn(1'b0, 10'd0, 4'hF, 32'h0, 3, S_SC, 32'h8086_1AF4, "R4 vis off retries");
    // R3 marker synthesis
    cfg_vis_en = 1'b1;
    run_txn(1'b0, 10'd0, 4'hF, 32'h0, 2, S_SC, 32'h0, "R3 full dword");
    run_txn(1'b0, 10'd0, 4'h3, 32'h0, 1, S_SC, 32'h0, "R3 vid only");
    run_txn(1'b0, 10'd0, 4'h7, 32'h0, 5, S_SC, 32'h0, "R3 three bytes");
    // R5 vis on but not a Vendor ID read
    run_txn(1'b1, 10'd0, 4'hF, 32'hAAAA_5555, 2, S_SC, 32'h0, "R5 write");
    run_txn(1'b0, 10'd0, 4'h1, 32'h0, 2, S_SC, 32'h0000_00AB, "R5 partial be");
    run_txn(1'b0, 10'd0, 4'hE, 32'h0, 2, S_SC, 32'h1234_0000, "R5 upper bytes");
    run_txn(1'b0, 10'd3, 4'hF, 32'h0, 2, S_SC, 32'h0BAD_F00D, "R5 other register");
    // R6 limit boundaries
    cfg_vis_en = 1'b0; cfg_retry_limit = 8'd3;
    run_txn(1'b0, 10'd0, 4'hF, 32'h0, 2, S_SC, 32'h0102_0304, "R6 below limit");
    run_txn(1'b0, 10'd0, 4'hF, 32'h0, 3, S_SC, 32'h0506_0708, "R6 at limit");
    run_txn(1'b0, 10'd0, 4'hF, 32'h0, 4, S_SC, 32'h090A_0B0C, "R6 over limit");
    cfg_retry_limit = 8'd1;
    run_txn(1'b1, 10'd9, 4'hF, 32'h7777_0000, 6, S_SC, 32'h0, "R6 limit one");
    // R10 counter cleared per request
    cfg_retry_limit = 8'd2;
    run_txn(1'b0, 10'd5, 4'hF, 32'h0, 2, S_SC, 32'hDEAD_0001, "R10 first");
    run_txn(1'b0, 10'd5, 4'hF, 32'h0, 2, S_SC, 32'hDEAD_0002, "R10 second");
    // R7 unlimited
    cfg_retry_limit = 8'd0;
    run_txn(1'b0, 10'd7, 4'hF, 32'h0, 40, S_SC, 32'hBEEF_0007, "R7 long unlimited");

    for (int i = 0; i < 60; i++) begin
      logic [2:0] fin;
      logic [3:0] be;
      case ($urandom_range(0, 3))
        0: fin = S_SC; 1: fin = S_UR; 2: fin = S_CA; default: fin = S_SC;
      endcase
      be = 4'($urandom_range(1, 15));
      cfg_vis_en = 1'($urandom_range(0, 1));
      cfg_retry_limit = 8'($urandom_range(0, 3));
      run_txn(1'($urandom_range(0, 1)), ($urandom_range(0, 1) == 0) ? 10'd0 : 10'($urandom_range(1, 1023)),
              be, $urandom, $urandom_range(0, 4), fin, $urandom, "random R3 R5 R6 R8 R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule